// File: doc/BRIEF.md
# Multi-Mode Programmable Countdown Channel

This block is a single down-counter channel. It counts on the falling edges of its counter clock and samples a gate input on the rising edges. A host register block supplies a mode code, a BCD/binary select and a reload value, together with a one-cycle strobe that marks a write. The channel drives one output line and also exposes the current count and a flag. The flag shows whether the most recently written reload value has reached the counter yet.

Five behaviours are supported:

- an output that rises at terminal count;
- a one-shot that the gate retriggers;
- a rate generator with a one-cycle low pulse;
- a strobe started by a write;
- a strobe started by the gate.

The host inputs and the gate are captured on a rising edge. The counter acts on the falling edge that follows, so a load always lands on its own edge and decrementing starts one edge later. A write whose mode code matches the running mode is treated as a new count only. In the gate-triggered modes and the rate generator, such a value waits for the next natural reload point. In every other case the write restarts the channel in the new mode.

Top module: `cdown_channel`

## Requirements
- R1: With `bcd_sel` low the count decrements as a 16-bit binary number, and 0x0000 steps to 0xFFFF. With `bcd_sel` high each 4-bit nibble is a decimal digit 0..9, a digit at 0 becomes 9 and borrows from the digit above, and 0x0000 steps to 0x9999.
- R2: `reload_wr`, `mode_sel`, `bcd_sel`, `reload_val` and `gate` are sampled on the rising edge of `clk`. A write that loads immediately places the value in `cur_count` on the next falling edge, and the first decrement happens on the falling edge after that.
- R3: In modes 0, 2 and 4 a falling edge decrements only if `gate` was high at the rising edge just before it. Otherwise the count holds.
- R4: Mode 0 (`mode_sel` = 0): the load edge drives `out` low. `out` goes high on the edge where the count steps from 1 to 0 and stays high while counting continues. Any later mode-0 write reloads the count and drives `out` low again.
- R5: Mode 1: after the write, `out` is high and the count is not loaded. The first falling edge after a sampled gate rising edge loads the count, drives `out` low and sets `count_loaded`. Counting then ignores the gate level, and `out` rises when the count steps from 1 to 0. A later gate rising edge reloads the count and restarts the cycle.
- R6: Mode 2: `out` goes low on the edge where the count steps from 2 to 1. On the next edge the count reloads and `out` returns high, so each period has exactly one low clock cycle. A reload value of 1 is not permitted.
- R7: Mode 2: while `gate` is low, `out` is high at once (combinationally) and counting stops. On the first falling edge after the gate is again sampled high, the count reloads with `out` high.
- R8: Mode 4: `out` is low for exactly one clock cycle, starting at the edge where the count steps from 1 to 0. This happens once per load. A low gate freezes the count without reloading it or touching `out`.
- R9: Mode 5: the same as mode 4, except that the count is loaded on the first falling edge after a sampled gate rising edge. After that load, counting does not depend on the gate level.
- R10: In modes 1, 2 and 5, a write that repeats the running mode only stores the value and clears `count_loaded`. The value reaches the counter at the next automatic reload or gate retrigger, and `count_loaded` is set again on that same edge.
- R11: A reload value of 0 is loaded as 0, so the next decrement gives 0xFFFF (binary) or 0x9999 (BCD). This makes it a count of 65536 or 10000.
- R12: Mode codes 3, 6 and 7 idle the channel: `out` high, count frozen, `count_loaded` low.
- R13: While `rst` is high at a falling edge, the channel clears the count to 0, drives `out` high and drives `count_loaded` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock: gate and host inputs sampled on rise, counting on fall |
| rst | input | 1 | Synchronous active-high reset |
| gate | input | 1 | Gate input |
| mode_sel | input | 3 | Mode code 0..7 |
| bcd_sel | input | 1 | 1 = BCD counting, 0 = binary |
| reload_val | input | 16 | Reload value written by the host |
| reload_wr | input | 1 | One-cycle write strobe for the reload value and mode |
| out | output | 1 | Channel output |
| cur_count | output | 16 | Current count |
| count_loaded | output | 1 | 1 once the latest written reload value is in the counter |

## Verification
A wrong count or a missed load appears on `cur_count` one clock cycle later. In mode 0 or mode 4 it also moves the edge of `out` by the same number of cycles as the count error. A broken gate-edge detector shows as an empty `out` or a count that stays constant for the whole one-shot window. A stuck deferral flag shows as `count_loaded` staying low past the next reload edge. A wrong BCD borrow is visible on the first digit rollover, for example 0x0100 stepping to something other than 0x0099. A rate generator that keeps its low phase shows a second low cycle right after the pulse.

// File: rtl/cdown_pkg.sv
`timescale 1ns/1ps
package cdown_pkg;

    typedef enum logic [2:0] {
        MD_TERM    = 3'd0,
        MD_ONESHOT = 3'd1,
        MD_RATE    = 3'd2,
        MD_RSVD3   = 3'd3,
        MD_SWSTB   = 3'd4,
        MD_HWSTB   = 3'd5,
        MD_RSVD6   = 3'd6,
        MD_RSVD7   = 3'd7
    } cd_mode_e;

    typedef struct packed {
        logic     valid;
        cd_mode_e mode;
        logic     bcd;
    } cd_cmd_t;

    function automatic logic mode_supported(cd_mode_e m);
        return (m == MD_TERM) || (m == MD_ONESHOT) || (m == MD_RATE) ||
               (m == MD_SWSTB) || (m == MD_HWSTB);
    endfunction

    function automatic logic mode_defers(cd_mode_e m);
        return (m == MD_ONESHOT) || (m == MD_RATE) || (m == MD_HWSTB);
    endfunction

endpackage

// File: rtl/cdown_sampler.sv
`timescale 1ns/1ps
module cdown_sampler
    import cdown_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         gate,
    input  logic [2:0]   mode_in,
    input  logic         bcd_in,
    input  logic [W-1:0] value_in,
    input  logic         wr_in,
    output logic         gate_q,
    output cd_cmd_t      cmd_q,
    output logic [W-1:0] value_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q  <= 1'b0;
            cmd_q   <= '0;
            value_q <= '0;
        end else begin
            gate_q     <= gate;
            cmd_q.valid <= wr_in;
            cmd_q.mode <= cd_mode_e'(mode_in);
            cmd_q.bcd  <= bcd_in;
            value_q    <= value_in;
        end
    end

endmodule

// File: rtl/cdown_dec.sv
`timescale 1ns/1ps
module cdown_dec #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         bcd,
    output logic [W-1:0] nxt
);

    localparam int NDIG = W / 4;

    logic [W-1:0]    bin_nxt;
    logic [W-1:0]    bcd_nxt;
    logic [NDIG-1:0] brw;

    assign bin_nxt = val - {{(W-1){1'b0}}, 1'b1};
    assign brw[0]  = 1'b1;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        logic [3:0] d;
        assign d = val[4*i +: 4];
        assign bcd_nxt[4*i +: 4] = !brw[i] ? d : ((d == 4'd0) ? 4'd9 : d - 4'd1);
        if (i < NDIG - 1) begin : g_chain
            assign brw[i+1] = brw[i] && (d == 4'd0);
        end
    end

    assign nxt = bcd ? bcd_nxt : bin_nxt;

endmodule

// File: rtl/cdown_core.sv
`timescale 1ns/1ps
module cdown_core
    import cdown_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         gate,
    input  logic         gate_q,
    input  cd_cmd_t      cmd,
    input  logic [W-1:0] value_q,
    output logic         out,
    output logic [W-1:0] cnt,
    output logic         loaded
);

    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    cd_mode_e     mode_r;
    logic         bcd_r, cfg_r;
    logic         out_r, loaded_r, armed_r, fired_r, rl_req_r, gate_last_r;
    logic [W-1:0] cnt_r, reload_r, dec_val, rl_val;
    logic         grise, defer, restart, cnt_one, cnt_two;

    cdown_dec #(.W(W)) u_dec (
        .val (cnt_r),
        .bcd (bcd_r),
        .nxt (dec_val)
    );

    always_comb begin
        grise   = gate_q && !gate_last_r;
        defer   = cmd.valid && cfg_r && (cmd.mode == mode_r) && mode_defers(cmd.mode);
        restart = cmd.valid && !defer;
        rl_val  = cmd.valid ? value_q : reload_r;
        cnt_one = (cnt_r == ONE);
        cnt_two = (cnt_r == TWO);
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            mode_r      <= MD_RSVD7;
            bcd_r       <= 1'b0;
            cfg_r       <= 1'b0;
            out_r       <= 1'b1;
            loaded_r    <= 1'b0;
            armed_r     <= 1'b0;
            fired_r     <= 1'b0;
            rl_req_r    <= 1'b0;
            gate_last_r <= 1'b0;
            cnt_r       <= '0;
            reload_r    <= '0;
        end else begin
            gate_last_r <= gate_q;
            if (cmd.valid) begin
                reload_r <= value_q;
                cfg_r    <= 1'b1;
            end
            if (restart) begin
                mode_r   <= cmd.mode;
                bcd_r    <= cmd.bcd;
                fired_r  <= 1'b0;
                rl_req_r <= 1'b0;
                armed_r  <= 1'b0;
                case (cmd.mode)
                    MD_TERM: begin
                        cnt_r    <= value_q;
                        out_r    <= 1'b0;
                        loaded_r <= 1'b1;
                    end
                    MD_RATE, MD_SWSTB: begin
                        cnt_r    <= value_q;
                        out_r    <= 1'b1;
                        loaded_r <= 1'b1;
                    end
                    default: begin
                        out_r    <= 1'b1;
                        loaded_r <= 1'b0;
                    end
                endcase
            end else begin
                if (defer) loaded_r <= 1'b0;
                case (mode_r)
                    MD_TERM: begin
                        if (gate_q) begin
                            cnt_r <= dec_val;
                            if (cnt_one) out_r <= 1'b1;
                        end
                    end
                    MD_ONESHOT: begin
                        if (grise) begin
                            cnt_r    <= rl_val;
                            out_r    <= 1'b0;
                            armed_r  <= 1'b1;
                            loaded_r <= 1'b1;
                        end else if (armed_r) begin
                            cnt_r <= dec_val;
                            if (cnt_one) out_r <= 1'b1;
                        end
                    end
                    MD_RATE: begin
                        if (!gate_q) begin
                            out_r    <= 1'b1;
                            rl_req_r <= 1'b1;
                        end else if (rl_req_r || cnt_one) begin
                            cnt_r    <= rl_val;
                            out_r    <= 1'b1;
                            rl_req_r <= 1'b0;
                            loaded_r <= 1'b1;
                        end else begin
                            cnt_r <= dec_val;
                            if (cnt_two) out_r <= 1'b0;
                        end
                    end
                    MD_SWSTB: begin
                        if (!out_r) out_r <= 1'b1;
                        if (gate_q) begin
                            cnt_r <= dec_val;
                            if (cnt_one && !fired_r) begin
                                out_r   <= 1'b0;
                                fired_r <= 1'b1;
                            end
                        end
                    end
                    MD_HWSTB: begin
                        if (!out_r) out_r <= 1'b1;
                        if (grise) begin
                            cnt_r    <= rl_val;
                            armed_r  <= 1'b1;
                            fired_r  <= 1'b0;
                            loaded_r <= 1'b1;
                        end else if (armed_r) begin
                            cnt_r <= dec_val;
                            if (cnt_one && !fired_r) begin
                                out_r   <= 1'b0;
                                fired_r <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign out    = out_r | ((mode_r == MD_RATE) && !gate);
    assign cnt    = cnt_r;
    assign loaded = loaded_r;

    AST_LOAD_ON_NEXT_EDGE: assert property (@(negedge clk) disable iff (rst)
        (cmd.valid && cmd.mode == MD_TERM) |=> (cnt_r == $past(value_q))); // R2
    AST_GATE_FREEZE: assert property (@(negedge clk) disable iff (rst)
        (mode_r == MD_SWSTB && !gate_q && !cmd.valid) |=> $stable(cnt_r)); // R3
    AST_TERM_OUT_STICKY: assert property (@(negedge clk) disable iff (rst)
        (mode_r == MD_TERM && out_r && !cmd.valid) |=> out_r); // R4
    AST_RATE_SINGLE_LOW: assert property (@(negedge clk) disable iff (rst)
        (mode_r == MD_RATE && !out_r && !cmd.valid) |=> out_r); // R6
    AST_SWSTB_ONE_CYCLE: assert property (@(negedge clk) disable iff (rst)
        (mode_r == MD_SWSTB && !out_r && !cmd.valid) |=> out_r); // R8
    AST_HWSTB_ONE_CYCLE: assert property (@(negedge clk) disable iff (rst)
        (mode_r == MD_HWSTB && !out_r && !cmd.valid) |=> out_r); // R9
    AST_IDLE_FROZEN: assert property (@(negedge clk) disable iff (rst)
        (!mode_supported(mode_r) && !cmd.valid) |=> ($stable(cnt_r) && out_r)); // R12

endmodule

// File: rtl/cdown_channel.sv
`timescale 1ns/1ps
module cdown_channel
    import cdown_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate,
    input  logic [2:0]       mode_sel,
    input  logic             bcd_sel,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             reload_wr,
    output logic             out,
    output logic [CNT_W-1:0] cur_count,
    output logic             count_loaded
);

    logic             gate_q;
    cd_cmd_t          cmd_q;
    logic [CNT_W-1:0] value_q;

    cdown_sampler #(.W(CNT_W)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .gate     (gate),
        .mode_in  (mode_sel),
        .bcd_in   (bcd_sel),
        .value_in (reload_val),
        .wr_in    (reload_wr),
        .gate_q   (gate_q),
        .cmd_q    (cmd_q),
        .value_q  (value_q)
    );

    cdown_core #(.W(CNT_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .gate    (gate),
        .gate_q  (gate_q),
        .cmd     (cmd_q),
        .value_q (value_q),
        .out     (out),
        .cnt     (cur_count),
        .loaded  (count_loaded)
    );

endmodule

// File: tb/cdown_channel_tb.sv
`timescale 1ns/1ps
module cdown_channel_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gate = 1'b0;
    logic [2:0]  mode_sel = 3'd0;
    logic        bcd_sel = 1'b0;
    logic [15:0] reload_val = 16'd0;
    logic        reload_wr = 1'b0;
    logic        out;
    logic [15:0] cur_count;
    logic        count_loaded;

    int vec = 0;
    int mis = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          at;
        string       req;
        logic        e_out;
        logic [15:0] e_cnt;
        logic        e_ld;
        bit          chk_ld;
    } item_t;

    item_t sb[$];

    cdown_channel u_dut (
        .clk          (clk),
        .rst          (rst),
        .gate         (gate),
        .mode_sel     (mode_sel),
        .bcd_sel      (bcd_sel),
        .reload_val   (reload_val),
        .reload_wr    (reload_wr),
        .out          (out),
        .cur_count    (cur_count),
        .count_loaded (count_loaded)
    );

    always #10 clk = ~clk;

    task automatic push(int at, string req, logic eo, logic [15:0] ec, logic el, bit cl);
        item_t it;
        it.at = at; it.req = req; it.e_out = eo; it.e_cnt = ec; it.e_ld = el; it.chk_ld = cl;
        sb.push_back(it);
    endtask

    // monitor: pops items that mature at this cycle
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            #2;
            for (int i = 0; i < sb.size(); ) begin
                if (sb[i].at == cyc) begin
                    vec++;
                    if (out !== sb[i].e_out || cur_count !== sb[i].e_cnt ||
                        (sb[i].chk_ld && count_loaded !== sb[i].e_ld)) begin
                        mis++;
                        $display("FAIL %s cyc %0d: out=%b cnt=%h ld=%b expected out=%b cnt=%h ld=%b",
                                 sb[i].req, cyc, out, cur_count, count_loaded,
                                 sb[i].e_out, sb[i].e_cnt, sb[i].e_ld);
                    end
                    sb.delete(i);
                end else begin
                    i++;
                end
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic wait_to(int c);
        while (cyc < c) step();
    endtask

    task automatic hwrite(logic [2:0] m, logic b, logic [15:0] v);
        mode_sel = m; bcd_sel = b; reload_val = v; reload_wr = 1'b1;
        step();
        reload_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        reload_wr = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        push(cyc + 1, "R13", 1'b1, 16'h0000, 1'b0, 1'b1);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mis++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        int w;
        int w2;
        step();

        // mode 0, binary, then a repeated count write
        do_reset();
        gate = 1'b1;
        w = cyc;
        push(w+2, "R2", 1'b0, 16'd5, 1'b1, 1'b1);
        push(w+3, "R2", 1'b0, 16'd4, 1'b1, 1'b1);
        push(w+4, "R4", 1'b0, 16'd3, 1'b1, 1'b0);
        push(w+6, "R4", 1'b0, 16'd1, 1'b1, 1'b0);
        push(w+7, "R4", 1'b1, 16'd0, 1'b1, 1'b0);
        push(w+8, "R1", 1'b1, 16'hFFFF, 1'b1, 1'b0);
        push(w+9, "R4", 1'b1, 16'hFFFE, 1'b1, 1'b0);
        push(w+10, "R4", 1'b0, 16'd2, 1'b1, 1'b1);
        push(w+12, "R4", 1'b1, 16'd0, 1'b1, 1'b0);
        hwrite(3'd0, 1'b0, 16'd5);
        wait_to(w+8);
        hwrite(3'd0, 1'b0, 16'd2);
        wait_to(w+13);

        // mode 4 with gate pause
        do_reset();
        gate = 1'b1;
        w = cyc;
        push(w+2, "R8", 1'b1, 16'd4, 1'b1, 1'b1);
        push(w+3, "R8", 1'b1, 16'd3, 1'b1, 1'b0);
        push(w+4, "R3", 1'b1, 16'd3, 1'b1, 1'b0);
        push(w+5, "R3", 1'b1, 16'd3, 1'b1, 1'b0);
        push(w+6, "R3", 1'b1, 16'd2, 1'b1, 1'b0);
        push(w+7, "R8", 1'b1, 16'd1, 1'b1, 1'b0);
        push(w+8, "R8", 1'b0, 16'd0, 1'b1, 1'b0);
        push(w+9, "R8", 1'b1, 16'hFFFF, 1'b1, 1'b0);
        hwrite(3'd4, 1'b0, 16'd4);
        wait_to(w+2);
        gate = 1'b0;
        wait_to(w+4);
        gate = 1'b1;
        wait_to(w+10);

        // mode 2 pulse train and gate stop
        do_reset();
        gate = 1'b1;
        w = cyc;
        push(w+2, "R6", 1'b1, 16'd3, 1'b1, 1'b1);
        push(w+3, "R6", 1'b1, 16'd2, 1'b1, 1'b0);
        push(w+4, "R6", 1'b0, 16'd1, 1'b1, 1'b0);
        push(w+5, "R6", 1'b1, 16'd3, 1'b1, 1'b0);
        push(w+6, "R6", 1'b1, 16'd2, 1'b1, 1'b0);
        push(w+7, "R7", 1'b1, 16'd1, 1'b1, 1'b0);
        push(w+8, "R7", 1'b1, 16'd1, 1'b1, 1'b0);
        push(w+9, "R7", 1'b1, 16'd1, 1'b1, 1'b0);
        push(w+10, "R7", 1'b1, 16'd3, 1'b1, 1'b0);
        push(w+11, "R6", 1'b1, 16'd2, 1'b1, 1'b0);
        push(w+12, "R6", 1'b0, 16'd1, 1'b1, 1'b0);
        hwrite(3'd2, 1'b0, 16'd3);
        wait_to(w+6);
        gate = 1'b0;
        #1;
        vec++;
        if (out !== 1'b1) begin
            mis++;
            $display("FAIL R7 immediate: out=%b expected out=1", out);
        end
        wait_to(w+8);
        gate = 1'b1;
        wait_to(w+13);

        // mode 2 deferred reload value
        do_reset();
        gate = 1'b1;
        w = cyc;
        push(w+2, "R10", 1'b1, 16'd3, 1'b1, 1'b1);
        push(w+4, "R10", 1'b0, 16'd1, 1'b0, 1'b1);
        push(w+5, "R10", 1'b1, 16'd5, 1'b1, 1'b1);
        push(w+6, "R10", 1'b1, 16'd4, 1'b1, 1'b1);
        hwrite(3'd2, 1'b0, 16'd3);
        wait_to(w+2);
        hwrite(3'd2, 1'b0, 16'd5);
        wait_to(w+7);

        // mode 1 one-shot with retrigger
        do_reset();
        gate = 1'b0;
        w = cyc;
        push(w+2, "R5", 1'b1, 16'd0, 1'b0, 1'b1);
        push(w+4, "R5", 1'b0, 16'd3, 1'b1, 1'b1);
        push(w+5, "R5", 1'b0, 16'd2, 1'b1, 1'b0);
        push(w+6, "R5", 1'b0, 16'd1, 1'b1, 1'b0);
        push(w+7, "R5", 1'b1, 16'd0, 1'b1, 1'b0);
        push(w+8, "R5", 1'b1, 16'hFFFF, 1'b1, 1'b0);
        push(w+10, "R5", 1'b0, 16'd3, 1'b1, 1'b0);
        hwrite(3'd1, 1'b0, 16'd3);
        wait_to(w+2);
        gate = 1'b1;
        wait_to(w+4);
        gate = 1'b0;
        wait_to(w+8);
        gate = 1'b1;
        wait_to(w+11);

        // mode 5 gate-started strobe
        do_reset();
        gate = 1'b0;
        w = cyc;
        push(w+2, "R9", 1'b1, 16'd0, 1'b0, 1'b1);
        push(w+3, "R9", 1'b1, 16'd0, 1'b0, 1'b1);
        push(w+4, "R9", 1'b1, 16'd2, 1'b1, 1'b1);
        push(w+5, "R9", 1'b1, 16'd1, 1'b1, 1'b0);
        push(w+6, "R9", 1'b0, 16'd0, 1'b1, 1'b0);
        push(w+7, "R9", 1'b1, 16'hFFFF, 1'b1, 1'b0);
        hwrite(3'd5, 1'b0, 16'd2);
        wait_to(w+2);
        gate = 1'b1;
        wait_to(w+8);

        // BCD mode 0 from zero, then a digit-borrow value
        do_reset();
        gate = 1'b1;
        w = cyc;
        push(w+2, "R11", 1'b0, 16'h0000, 1'b1, 1'b1);
        push(w+3, "R11", 1'b0, 16'h9999, 1'b1, 1'b0);
        push(w+4, "R1", 1'b0, 16'h9998, 1'b1, 1'b0);
        push(w+5, "R1", 1'b0, 16'h9997, 1'b1, 1'b0);
        push(w+6, "R4", 1'b0, 16'h0100, 1'b1, 1'b1);
        push(w+7, "R1", 1'b0, 16'h0099, 1'b1, 1'b0);
        hwrite(3'd0, 1'b1, 16'h0000);
        wait_to(w+4);
        w2 = cyc;
        hwrite(3'd0, 1'b1, 16'h0100);
        wait_to(w2+4);

        // binary zero reload in mode 4
        do_reset();
        gate = 1'b1;
        w = cyc;
        push(w+2, "R11", 1'b1, 16'h0000, 1'b1, 1'b1);
        push(w+3, "R11", 1'b1, 16'hFFFF, 1'b1, 1'b0);
        hwrite(3'd4, 1'b0, 16'h0000);
        wait_to(w+4);

        // unsupported mode code 3
        do_reset();
        gate = 1'b1;
        w = cyc;
        push(w+2, "R12", 1'b1, 16'h0000, 1'b0, 1'b1);
        push(w+4, "R12", 1'b1, 16'h0000, 1'b0, 1'b1);
        hwrite(3'd3, 1'b0, 16'd5);
        wait_to(w+5);

        step();
        while (sb.size() > 0) begin
            mis++;
            $display("FAIL %s: item for cycle %0d never compared, actual none expected cnt=%h",
                     sb[0].req, sb[0].at, sb[0].e_cnt);
            sb.delete(0);
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule